// File: doc/BRIEF.md
# True dual-port RAM with collision marking

Two ports, A and B, read and write one shared storage array on a single clock. Each port has its own address, write data, write enable and read data. A write also sends the written word straight to that port's own read output, so the writing port sees its new data without waiting. The parameter `OUT_REG` picks how fast results appear. With `OUT_REG` = 0 a result appears just after the clock edge that samples the request. With `OUT_REG` = 1 a pipeline register adds one more cycle.

Both ports may write the same address on the same edge. The block does not pick a winner. It stores the pattern `POISON` (all ones by default) in that word and clears the word's valid bit. It also raises a one-cycle `collision` pulse. Any later read of a poisoned word, or of a word not written since reset, returns its per-port invalid flag set alongside the data. A later write by one port alone makes the word good again. Storage contents are not cleared by reset; only the valid bits are.

Top module: `tdp_ram_poison`

## Requirements
- R1: `rst` is synchronous and active high. On the edge where it is sampled high, all valid bits are cleared, and `a_rdata`, `b_rdata`, `a_rd_invalid`, `b_rd_invalid` and `collision` go to 0. Any word read afterwards, before it has been written, returns its invalid flag at 1.
- R2: A word written by one port reads back with the same data and invalid flag 0 on either port, because both ports share one array.
- R3: On a write, that port's read data shows the write data and its invalid flag is 0, unless the write is part of a collision.
- R4: With `OUT_REG` = 0, read data, invalid flags and `collision` are valid in the cycle after the edge that samples the request. With `OUT_REG` = 1 they appear one cycle later and are otherwise identical.
- R5: When one port reads an address that the other port writes on the same edge, the reading port returns the word's previous data and previous invalid flag.
- R6: `collision` is 1 for exactly one output cycle for each edge on which both write enables are 1 and the addresses are equal. It stays 0 when both ports write different addresses.
- R7: After a collision, both colliding ports' outputs show their own write data with the invalid flag at 1. Later reads of that word return `POISON` with the invalid flag at 1.
- R8: A write by a single port to a poisoned word stores the new data and clears the invalid state.
- R9: Simultaneous writes by both ports to different addresses both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_rd_invalid | output | 1 | Port A: the returned word is poisoned or unwritten |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_rd_invalid | output | 1 | Port B: the returned word is poisoned or unwritten |
| collision | output | 1 | Pulse: both ports wrote the same address |

## Verification
A write on one port can fall on the same edge as an access by the other port to the same address. That access is either a read, which must see the old word, or a write, which must poison the word. Vectors drive both cases on addresses that already hold known data. The reader's old data or poison state is predicted from the earlier vectors. Each collision is judged by the pulse, by the two write-through outputs with their invalid flags, and by reads of the word on the next cycles. Two instances, one per `OUT_REG` value, share the stimulus. The registered one is held to the unregistered one's expectations one cycle later.

// File: rtl/tdp_ram_poison.sv
module tdp_ram_poison #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter bit OUT_REG = 1'b0,
  parameter logic [DATA_W-1:0] POISON = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rd_invalid,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rd_invalid,
  output logic              collision
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;
  logic [DATA_W-1:0] a_q, b_q;
  logic              a_qi, b_qi, coll_q;

  wire clash = a_we & b_we & (a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (clash) mem[a_addr] <= POISON;
      else begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid <= '0;
    else if (clash) valid[a_addr] <= 1'b0;
    else begin
      if (a_we) valid[a_addr] <= 1'b1;
      if (b_we) valid[b_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; a_qi <= 1'b0;
      b_q <= '0; b_qi <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      a_q  <= a_we ? a_wdata : mem[a_addr];
      a_qi <= a_we ? clash : ~valid[a_addr];
      b_q  <= b_we ? b_wdata : mem[b_addr];
      b_qi <= b_we ? clash : ~valid[b_addr];
      coll_q <= clash;
    end
  end

  generate
    if (OUT_REG) begin : g_outreg
      always_ff @(posedge clk) begin
        if (rst) begin
          a_rdata <= '0; a_rd_invalid <= 1'b0;
          b_rdata <= '0; b_rd_invalid <= 1'b0;
          collision <= 1'b0;
        end else begin
          a_rdata <= a_q; a_rd_invalid <= a_qi;
          b_rdata <= b_q; b_rd_invalid <= b_qi;
          collision <= coll_q;
        end
      end
    end else begin : g_direct
      assign a_rdata = a_q;
      assign a_rd_invalid = a_qi;
      assign b_rdata = b_q;
      assign b_rd_invalid = b_qi;
      assign collision = coll_q;
    end
  endgenerate

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    (a_we && !clash) |=> (valid[$past(a_addr)] && mem[$past(a_addr)] == $past(a_wdata))); // R2
  AST_A_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
    a_we |=> (a_q == $past(a_wdata))); // R3
  AST_B_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
    b_we |=> (b_q == $past(b_wdata))); // R3
  AST_MIXED_OLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (!a_we && b_we && a_addr == b_addr) |=> (a_q == $past(mem[a_addr]))); // R5
  AST_COLL_BOTH_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    coll_q |-> (a_qi && b_qi)); // R6
  AST_CLASH_POISONS: assert property (@(posedge clk) disable iff (rst)
    clash |=> (!valid[$past(a_addr)] && mem[$past(a_addr)] == POISON)); // R7
endmodule

// File: tb/test_tdp_ram_poison.sv
module test_tdp_ram_poison;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_we = 1'b0, b_we = 1'b0;
  logic [7:0] a_addr = '0, b_addr = '0;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rd0, b_rd0, a_rd1, b_rd1;
  logic ai0, bi0, ai1, bi1, co0, co1;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  tdp_ram_poison #(.DATA_W(16), .ADDR_W(8), .OUT_REG(1'b0)) i_tdp_ram_poison (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rd0), .a_rd_invalid(ai0),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd0), .b_rd_invalid(bi0),
    .collision(co0));

  tdp_ram_poison #(.DATA_W(16), .ADDR_W(8), .OUT_REG(1'b1)) i_tdp_ram_poison_reg (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rd1), .a_rd_invalid(ai1),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd1), .b_rd_invalid(bi1),
    .collision(co1));

  typedef struct packed {
    logic ca; logic [15:0] ad; logic ai;
    logic cb; logic [15:0] bd; logic bi;
    logic co;
  } exp_t;

  typedef struct packed {
    logic awe; logic [7:0] aad; logic [15:0] awd;
    logic bwe; logic [7:0] bad; logic [15:0] bwd;
    exp_t e;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 16'h1111, 1'b0, 8'h10, 16'h0, '{1'b1, 16'h1111, 1'b0, 1'b0, 16'h0,    1'b1, 1'b0}},
    '{1'b0, 8'h10, 16'h0,    1'b0, 8'h20, 16'h0, '{1'b1, 16'h1111, 1'b0, 1'b0, 16'h0,    1'b1, 1'b0}},
    '{1'b0, 8'h20, 16'h0,    1'b1, 8'h20, 16'h2222, '{1'b0, 16'h0, 1'b1, 1'b1, 16'h2222, 1'b0, 1'b0}},
    '{1'b0, 8'h20, 16'h0,    1'b0, 8'h10, 16'h0, '{1'b1, 16'h2222, 1'b0, 1'b1, 16'h1111, 1'b0, 1'b0}},
    '{1'b1, 8'h30, 16'h3333, 1'b1, 8'h31, 16'h4444, '{1'b1, 16'h3333, 1'b0, 1'b1, 16'h4444, 1'b0, 1'b0}},
    '{1'b0, 8'h31, 16'h0,    1'b0, 8'h30, 16'h0, '{1'b1, 16'h4444, 1'b0, 1'b1, 16'h3333, 1'b0, 1'b0}},
    '{1'b1, 8'h10, 16'h5555, 1'b0, 8'h10, 16'h0, '{1'b1, 16'h5555, 1'b0, 1'b1, 16'h1111, 1'b0, 1'b0}},
    '{1'b0, 8'h10, 16'h0,    1'b1, 8'h40, 16'h6666, '{1'b1, 16'h5555, 1'b0, 1'b1, 16'h6666, 1'b0, 1'b0}},
    '{1'b1, 8'h50, 16'hAAAA, 1'b1, 8'h50, 16'hBBBB, '{1'b1, 16'hAAAA, 1'b1, 1'b1, 16'hBBBB, 1'b1, 1'b1}},
    '{1'b0, 8'h50, 16'h0,    1'b0, 8'h50, 16'h0, '{1'b1, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0}},
    '{1'b1, 8'h50, 16'h7777, 1'b0, 8'h50, 16'h0, '{1'b1, 16'h7777, 1'b0, 1'b1, 16'hFFFF, 1'b1, 1'b0}},
    '{1'b0, 8'h50, 16'h0,    1'b0, 8'h50, 16'h0, '{1'b1, 16'h7777, 1'b0, 1'b1, 16'h7777, 1'b0, 1'b0}},
    '{1'b1, 8'h10, 16'h1234, 1'b1, 8'h10, 16'h4321, '{1'b1, 16'h1234, 1'b1, 1'b1, 16'h4321, 1'b1, 1'b1}},
    '{1'b0, 8'h10, 16'h0,    1'b1, 8'h10, 16'h9999, '{1'b1, 16'hFFFF, 1'b1, 1'b1, 16'h9999, 1'b0, 1'b0}},
    '{1'b0, 8'h10, 16'h0,    1'b0, 8'h30, 16'h0, '{1'b1, 16'h9999, 1'b0, 1'b1, 16'h3333, 1'b0, 1'b0}},
    '{1'b0, 8'h30, 16'h0,    1'b0, 8'h30, 16'h0, '{1'b1, 16'h3333, 1'b0, 1'b1, 16'h3333, 1'b0, 1'b0}}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 6:     return "R3 R5 write-through with mixed read";
      1, 3, 7:  return "R2 shared array readback";
      2:        return "R5 old invalid flag during other-port write";
      4, 5:     return "R9 dual write to distinct addresses";
      8, 12:    return "R6 R7 collision pulse and write-through";
      9:        return "R7 poisoned word readback";
      10, 13:   return "R8 R5 rewrite of poisoned word";
      default:  return "R8 R2 readback after rewrite";
    endcase
  endfunction

  exp_t prev;

  task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag, exp_t e);
    if (e.ca) cmp(tag, "a_rdata", a_rd0, e.ad);
    cmp(tag, "a_rd_invalid", {15'b0, ai0}, {15'b0, e.ai});
    if (e.cb) cmp(tag, "b_rdata", b_rd0, e.bd);
    cmp(tag, "b_rd_invalid", {15'b0, bi0}, {15'b0, e.bi});
    cmp(tag, "collision", {15'b0, co0}, {15'b0, e.co});
    if (prev.ca) cmp({tag, " R4 registered"}, "a_rdata", a_rd1, prev.ad);
    cmp({tag, " R4 registered"}, "a_rd_invalid", {15'b0, ai1}, {15'b0, prev.ai});
    if (prev.cb) cmp({tag, " R4 registered"}, "b_rdata", b_rd1, prev.bd);
    cmp({tag, " R4 registered"}, "b_rd_invalid", {15'b0, bi1}, {15'b0, prev.bi});
    cmp({tag, " R4 registered"}, "collision", {15'b0, co1}, {15'b0, prev.co});
    prev = e;
  endtask

  task automatic step(logic awe, logic [7:0] aad, logic [15:0] awd,
                      logic bwe, logic [7:0] bad, logic [15:0] bwd);
    a_we = awe; a_addr = aad; a_wdata = awd;
    b_we = bwe; b_addr = bad; b_wdata = bwd;
    @(posedge clk);
    @(negedge clk);
  endtask

  localparam exp_t ZERO = '{1'b1, 16'h0, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0};
  localparam exp_t UNWRITTEN = '{1'b0, 16'h0, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0};

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    prev = ZERO;
    check_all("R1 reset state", ZERO);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].awe, VECS[i].aad, VECS[i].awd, VECS[i].bwe, VECS[i].bad, VECS[i].bwd);
      check_all(vec_tag(i), VECS[i].e);
    end

    rst = 1'b1;
    step(1'b1, 8'h30, 16'hEEEE, 1'b1, 8'h31, 16'hDDDD);
    rst = 1'b0;
    prev = ZERO;
    check_all("R1 reset mid-run", ZERO);
    step(1'b0, 8'h10, 16'h0, 1'b0, 8'h30, 16'h0);
    check_all("R1 valid cleared by reset", UNWRITTEN);
    step(1'b0, 8'h31, 16'h0, 1'b0, 8'h40, 16'h0);
    check_all("R1 valid cleared by reset", UNWRITTEN);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule